// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block sits beside one private cache on a shared snooping bus and keeps a four-state coherence tag (Invalid, Shared, Exclusive, Modified) for every line of a small direct-mapped array. Each line also holds a tag and a single data word, so that fills, writes, write-backs and cache-to-cache transfers can be observed at the ports. The processor side is a valid/ready request port that is held until completion. The bus side raises a request, waits for a grant and performs its transaction in the granted cycle. During that cycle the wired-OR shared input and the fill data are sampled.

Transactions performed by other caches arrive on the snoop port, one per cycle and never in the same cycle as this cache's own grant. The block answers in the same cycle. It drives the shared line, drives the data-out strobe when it must or may supply the line, and updates the local state at the clock edge. The cache-to-cache supply from a clean copy is enabled by a parameter. An external selector input names the single cache allowed to drive it.

The address is split into an index (low `IDX_W` bits) and a tag (remaining bits). Bus command codes on `busCmd` and `snpCmd` are 0 none, 1 read (BusRd), 2 read-for-ownership (BusRdX), 3 upgrade (BusUpgr), 4 write-back.

Top module: `mesiSnoopCtrl`

## Requirements
- R1: After reset every line is Invalid, `busReq` and `cpuReady` are low, and a snooped read to any address leaves `snpShared` low.
- R2: A processor read that misses issues command 1 for the requested address. At the grant the line becomes Shared if `busSharedIn` is high and Exclusive if it is low, and `cpuRdata` returns `busDataIn` with `cpuReady` in that same cycle.
- R3: A processor read that hits a valid line completes with `cpuReady` high in the cycle it is presented, with no bus request, and returns the stored word.
- R4: A processor write to a line that is Invalid or not present issues command 2 and leaves the line Modified, holding the written word.
- R5: A processor write that hits an Exclusive or Modified line completes in the cycle it is presented, with no bus request, and leaves the line Modified.
- R6: A processor write that hits a Shared line issues command 3, not command 2. If a snoop invalidates the line while the request waits for its grant, the command issued becomes 2.
- R7: A snooped command 1 that hits a Modified line raises `snpFlush` with the stored word on `snpData`, and the line becomes Shared.
- R8: A snooped command 2 that hits a Modified line raises `snpFlush` with the stored word, and the line becomes Invalid. A snooped command 2 or 3 that hits a Shared or Exclusive line invalidates it without raising `snpFlush`.
- R9: A snooped command 1 raises `snpShared` exactly when this cache holds a valid copy, and an Exclusive copy becomes Shared. Commands 2 and 3 never raise `snpShared`.
- R10: With the cache-to-cache parameter set, a snooped command 1 that hits a Shared or Exclusive line raises `snpFlush` with the stored word only while `snpSupplySel` is high. It never raises `snpFlush` for a line that is not held.
- R11: A miss that displaces a Modified line with a different tag first issues command 4, carrying the old line's address and word, and only then the miss command. A displaced Exclusive or Shared line is dropped with no bus traffic.
- R12: While a request waits for `busGnt`, `busReq` stays high, `cpuReady` stays low and the line state is unchanged.
- R13: When a snoop addresses the same index in the cycle a processor hit would complete without the bus, the snoop is applied first. The processor request is then re-evaluated against the updated state, so an Exclusive write hit that loses its exclusivity issues command 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuValid | input | 1 | Processor request valid, held until `cpuReady` |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Request address (index in low bits) |
| cpuWdata | input | DATA_W | Word to write |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | DATA_W | Read result, valid with `cpuReady` |
| busReq | output | 1 | Bus request |
| busGnt | input | 1 | Grant; the transaction is performed in this cycle |
| busCmd | output | 3 | Command of the requested transaction |
| busAddr | output | ADDR_W | Address of the requested transaction |
| busDataOut | output | DATA_W | Word carried by a write-back |
| busSharedIn | input | 1 | Wired-OR shared line, sampled at the grant |
| busDataIn | input | DATA_W | Fill word, sampled at the grant |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 3 | Snooped command |
| snpAddr | input | ADDR_W | Snooped address |
| snpSupplySel | input | 1 | This cache is the chosen clean supplier |
| snpShared | output | 1 | Drive the shared line |
| snpFlush | output | 1 | Drive the line's word onto the bus |
| snpData | output | DATA_W | Word supplied with `snpFlush` |

## Verification
The bench covers every combination of starting state and event: processor read, processor write, and snooped read, read-for-ownership and upgrade. Each outcome state is then recovered by two independent probes, a processor write and a snooped read, because no single probe can tell all four states apart. An Exclusive line that wrongly answers a write with an upgrade, or an upgrade that is not converted to read-for-ownership after a racing invalidation, shows up as a wrong command. A design that skips the write-back, or issues the miss before it, shows the wrong order of commands on a conflict miss. A snoop-versus-hit collision checks that the local write does not silently overwrite a line that has just become Shared. Further checks confirm that the clean supply happens only under the selector, and that no state change is visible before the grant.

// File: rtl/mesiPkg.sv
package mesiPkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } lineState_t;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } busCmd_t;

  typedef enum logic [1:0] {
    DSEL_HOLD = 2'd0,
    DSEL_CPU  = 2'd1,
    DSEL_BUS  = 2'd2
  } dataSel_t;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_EVICT = 2'd1,
    FSM_MISS  = 2'd2
  } ctrlState_t;

  // strobes from control to the line store
  typedef struct packed {
    logic       cpuWr;
    lineState_t cpuState;
    logic       tagLoad;
    dataSel_t   dataSel;
    logic       snpWr;
    lineState_t snpState;
  } lineStrobe_t;

endpackage

// File: rtl/mesiLineStore.sv
module mesiLineStore
  import mesiPkg::*;
#(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [TAG_W-1:0]  cpuTag,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [IDX_W-1:0]  snpIdx,
  input  logic [TAG_W-1:0]  snpTag,
  input  lineStrobe_t       strobe,
  output lineState_t        cpuLineState,
  output logic              cpuTagHit,
  output logic [TAG_W-1:0]  cpuLineTag,
  output logic [DATA_W-1:0] cpuLineData,
  output lineState_t        snpLineState,
  output logic [DATA_W-1:0] snpLineData
);

  lineState_t        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];
  logic [LINES-1:0]  cpuSel;
  logic [LINES-1:0]  snpSel;

  for (genvar i = 0; i < LINES; i++) begin : gSel
    assign cpuSel[i] = strobe.cpuWr && (cpuIdx == IDX_W'(i));
    assign snpSel[i] = strobe.snpWr && (snpIdx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= ST_I;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snpSel[i]) begin
          stateQ[i] <= strobe.snpState;
        end else if (cpuSel[i]) begin
          stateQ[i] <= strobe.cpuState;
        end
        if (cpuSel[i] && strobe.tagLoad) begin
          tagQ[i] <= cpuTag;
        end
        if (cpuSel[i]) begin
          case (strobe.dataSel)
            DSEL_CPU: dataQ[i] <= cpuWdata;
            DSEL_BUS: dataQ[i] <= busDataIn;
            default:  dataQ[i] <= dataQ[i];
          endcase
        end
      end
    end
  end

  assign cpuLineState = stateQ[cpuIdx];
  assign cpuLineTag   = tagQ[cpuIdx];
  assign cpuTagHit    = (tagQ[cpuIdx] == cpuTag);
  assign cpuLineData  = dataQ[cpuIdx];
  assign snpLineState = (tagQ[snpIdx] == snpTag) ? stateQ[snpIdx] : ST_I;
  assign snpLineData  = dataQ[snpIdx];

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(|(cpuSel & snpSel))); // R13

endmodule

// File: rtl/mesiCtrl.sv
module mesiCtrl
  import mesiPkg::*;
#(
  parameter bit C2C_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuValid,
  input  logic        cpuWrite,
  input  lineState_t  cpuLineState,
  input  logic        cpuTagHit,
  input  logic        busGnt,
  input  logic        busSharedIn,
  input  logic        snpValid,
  input  logic [2:0]  snpCmd,
  input  logic        snpSameIdx,
  input  logic        snpSupplySel,
  input  lineState_t  snpLineState,
  output lineStrobe_t strobe,
  output logic        cpuReady,
  output logic        busReq,
  output busCmd_t     busCmd,
  output logic        useVictimAddr,
  output logic        snpShared,
  output logic        snpFlush
);

  ctrlState_t fsmQ, fsmD;
  logic hitValid, snpBlock, snpHit, silentHit;

  assign hitValid  = cpuTagHit && (cpuLineState != ST_I);
  assign silentHit = hitValid &&
                     (!cpuWrite || cpuLineState == ST_E || cpuLineState == ST_M);
  assign snpBlock  = snpValid && snpSameIdx;
  assign snpHit    = (snpLineState != ST_I);

  // processor side
  always_comb begin
    fsmD          = fsmQ;
    cpuReady      = 1'b0;
    busReq        = 1'b0;
    busCmd        = CMD_NONE;
    useVictimAddr = 1'b0;
    strobe.cpuWr    = 1'b0;
    strobe.cpuState = ST_I;
    strobe.tagLoad  = 1'b0;
    strobe.dataSel  = DSEL_HOLD;
    case (fsmQ)
      FSM_IDLE: begin
        if (cpuValid) begin
          if (silentHit) begin
            if (!snpBlock) begin
              cpuReady = 1'b1;
              if (cpuWrite) begin
                strobe.cpuWr    = 1'b1;
                strobe.cpuState = ST_M;
                strobe.dataSel  = DSEL_CPU;
              end
            end
          end else if (!cpuTagHit && cpuLineState == ST_M) begin
            fsmD = FSM_EVICT;
          end else begin
            fsmD = FSM_MISS;
          end
        end
      end
      FSM_EVICT: begin
        if (!cpuTagHit && cpuLineState == ST_M) begin
          busReq        = 1'b1;
          busCmd        = CMD_WB;
          useVictimAddr = 1'b1;
          if (busGnt) begin
            strobe.cpuWr    = 1'b1;
            strobe.cpuState = ST_I;
            fsmD            = FSM_MISS;
          end
        end else begin
          fsmD = FSM_MISS;
        end
      end
      FSM_MISS: begin
        busReq = 1'b1;
        if (!cpuWrite)                           busCmd = CMD_RD;
        else if (hitValid && cpuLineState == ST_S) busCmd = CMD_UPGR;
        else                                     busCmd = CMD_RDX;
        if (busGnt) begin
          cpuReady        = 1'b1;
          strobe.cpuWr    = 1'b1;
          strobe.tagLoad  = 1'b1;
          strobe.dataSel  = cpuWrite ? DSEL_CPU : DSEL_BUS;
          strobe.cpuState = cpuWrite ? ST_M : (busSharedIn ? ST_S : ST_E);
          fsmD            = FSM_IDLE;
        end
      end
      default: fsmD = FSM_IDLE;
    endcase
  end

  // snoop side
  always_comb begin
    snpShared       = 1'b0;
    snpFlush        = 1'b0;
    strobe.snpWr    = 1'b0;
    strobe.snpState = ST_I;
    if (snpValid && snpHit) begin
      case (snpCmd)
        CMD_RD: begin
          snpShared       = 1'b1;
          snpFlush        = (snpLineState == ST_M) ||
                            (C2C_EN && snpSupplySel);
          strobe.snpWr    = 1'b1;
          strobe.snpState = ST_S;
        end
        CMD_RDX: begin
          snpFlush        = (snpLineState == ST_M);
          strobe.snpWr    = 1'b1;
          strobe.snpState = ST_I;
        end
        CMD_UPGR: begin
          strobe.snpWr    = 1'b1;
          strobe.snpState = ST_I;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsmQ <= FSM_IDLE;
    else       fsmQ <= fsmD;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && fsmQ == FSM_MISS && cpuValid) |=> busReq); // R12
  AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid); // R12
  AST_ONE_BUS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    !(busGnt && snpValid)); // R12
  AST_FLUSH_NEEDS_COPY: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> (snpValid && snpLineState != ST_I)); // R10
  AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    snpShared |-> (snpValid && snpCmd == CMD_RD)); // R9
  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busGnt && busCmd == CMD_WB) |=> (fsmQ == FSM_MISS)); // R11

endmodule

// File: rtl/mesiSnoopCtrl.sv
module mesiSnoopCtrl
  import mesiPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 8,
  parameter bit C2C_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic [2:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  input  logic              busSharedIn,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpSupplySel,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [DATA_W-1:0] snpData
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineStrobe_t       strobe;
  lineState_t        cpuLineState, snpLineState;
  logic              cpuTagHit, useVictimAddr;
  logic [TAG_W-1:0]  cpuLineTag;
  logic [DATA_W-1:0] cpuLineData;
  busCmd_t           cmd;

  wire [IDX_W-1:0] cpuIdx = cpuAddr[IDX_W-1:0];
  wire [TAG_W-1:0] cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] snpIdx = snpAddr[IDX_W-1:0];
  wire [TAG_W-1:0] snpTag = snpAddr[ADDR_W-1:IDX_W];

  mesiLineStore #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .cpuIdx(cpuIdx), .cpuTag(cpuTag), .cpuWdata(cpuWdata),
    .busDataIn(busDataIn), .snpIdx(snpIdx), .snpTag(snpTag),
    .strobe(strobe),
    .cpuLineState(cpuLineState), .cpuTagHit(cpuTagHit),
    .cpuLineTag(cpuLineTag), .cpuLineData(cpuLineData),
    .snpLineState(snpLineState), .snpLineData(snpData)
  );

  mesiCtrl #(.C2C_EN(C2C_EN)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuLineState(cpuLineState), .cpuTagHit(cpuTagHit),
    .busGnt(busGnt), .busSharedIn(busSharedIn),
    .snpValid(snpValid), .snpCmd(snpCmd),
    .snpSameIdx(snpIdx == cpuIdx), .snpSupplySel(snpSupplySel),
    .snpLineState(snpLineState),
    .strobe(strobe), .cpuReady(cpuReady), .busReq(busReq),
    .busCmd(cmd), .useVictimAddr(useVictimAddr),
    .snpShared(snpShared), .snpFlush(snpFlush)
  );

  assign busCmd     = cmd;
  assign busAddr    = useVictimAddr ? {cpuLineTag, cpuIdx} : cpuAddr;
  assign busDataOut = useVictimAddr ? cpuLineData : cpuWdata;
  assign cpuRdata   = (strobe.dataSel == DSEL_BUS) ? busDataIn : cpuLineData;

endmodule

// File: tb/mesiSnoopCtrl_tb.sv
module mesiSnoopCtrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 0, cpuWrite = 0;
  logic [5:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0;
  logic cpuReady;
  logic [7:0] cpuRdata;
  logic busReq;
  logic busGnt = 0;
  logic [2:0] busCmd;
  logic [5:0] busAddr;
  logic [7:0] busDataOut;
  logic busSharedIn = 0;
  logic [7:0] busDataIn = '0;
  logic snpValid = 0;
  logic [2:0] snpCmd = '0;
  logic [5:0] snpAddr = '0;
  logic snpSupplySel = 0;
  logic snpShared, snpFlush;
  logic [7:0] snpData;

  int errors = 0, checks = 0;
  int nTx;
  int txCmd [4];
  int txAddr [4];
  int txData [4];
  int gotData;
  int snSh, snFl, snDt;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesiSnoopCtrl u_dut (
    .clk(clk), .rstN(rstN),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd), .busAddr(busAddr),
    .busDataOut(busDataOut), .busSharedIn(busSharedIn), .busDataIn(busDataIn),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupplySel(snpSupplySel), .snpShared(snpShared), .snpFlush(snpFlush),
    .snpData(snpData)
  );

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // processor request; grants each bus request after 'delay' waiting cycles
  task automatic cpuOp(input bit wr, input logic [5:0] addr, input logic [7:0] wd,
                       input bit shr, input logic [7:0] mem, input int delay);
    bit done = 0;
    int waitCnt = 0;
    nTx = 0;
    gotData = -1;
    @(negedge clk);
    cpuValid = 1; cpuWrite = wr; cpuAddr = addr; cpuWdata = wd;
    for (int cyc = 0; cyc < 64 && !done; cyc++) begin
      #1;
      if (busReq) begin
        if (waitCnt < delay) begin
          waitCnt++;
          if (cpuReady) chkEq("R12", "ready while waiting for grant", 1, 0);
        end else begin
          busGnt = 1; busSharedIn = shr; busDataIn = mem;
          #1;
          if (nTx < 4) begin
            txCmd[nTx] = int'(busCmd); txAddr[nTx] = int'(busAddr);
            txData[nTx] = int'(busDataOut);
          end
          nTx++;
          waitCnt = 0;
        end
      end
      if (cpuReady) begin
        gotData = int'(cpuRdata);
        done = 1;
      end
      @(negedge clk);
      busGnt = 0;
    end
    cpuValid = 0;
    if (!done) chkEq("R12", "request never completed", 0, 1);
  endtask

  task automatic snoop(input int cmd, input logic [5:0] addr, input bit sel, input int pre);
    repeat (pre) @(negedge clk);
    @(negedge clk);
    snpValid = 1; snpCmd = 3'(cmd); snpAddr = addr; snpSupplySel = sel;
    #1;
    snSh = int'(snpShared); snFl = int'(snpFlush); snDt = int'(snpData);
    @(negedge clk);
    snpValid = 0; snpSupplySel = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chkEq("WATCHDOG", "run timed out", 0, 1);
    summary();
  end

  initial begin
    int iter = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1: reset state
    chkEq("R1", "busReq after reset", int'(busReq), 0);
    chkEq("R1", "cpuReady after reset", int'(cpuReady), 0);
    for (int i = 0; i < 8; i++) begin
      snoop(1, 6'(i), 0, 0);
      chkEq("R1", "shared on empty line", snSh, 0);
    end

    // exhaustive sweep: probe kind x start state x event
    for (int pr = 0; pr < 2; pr++) begin
      for (int st = 0; st < 4; st++) begin
        for (int ev = 0; ev < 5; ev++) begin
          logic [5:0] a;
          logic [7:0] v, w, m, x, stored;
          int ns;
          string rq;
          if (st == 3 && ev == 4) continue;
          iter++;
          a = {3'd5, 3'(iter % 8)};
          v = 8'(8'h10 + iter); w = 8'(8'h80 + iter);
          m = 8'(8'h40 + iter); x = 8'(8'hC0 + iter);
          snoop(2, a, 0, 0);
          case (st)
            1: cpuOp(0, a, 8'h00, 1, v, 0);
            2: cpuOp(0, a, 8'h00, 0, v, 0);
            3: cpuOp(1, a, w, 0, 8'h00, 0);
            default: ;
          endcase
          stored = (st == 3) ? w : v;
          ns = st;
          case (ev)
            0: begin
              cpuOp(0, a, 8'h00, 0, m, 0);
              if (st == 0) begin
                rq = "R2"; ns = 2;
                chkEq(rq, "read miss tx count", nTx, 1);
                chkEq(rq, "read miss cmd", txCmd[0], 1);
                chkEq(rq, "read miss addr", txAddr[0], int'(a));
                chkEq(rq, "read miss data", gotData, int'(m));
              end else begin
                rq = "R3";
                chkEq(rq, "read hit tx count", nTx, 0);
                chkEq(rq, "read hit data", gotData, int'(stored));
              end
            end
            1: begin
              cpuOp(1, a, x, 0, 8'h00, 0);
              ns = 3;
              rq = (st == 0) ? "R4" : (st == 1) ? "R6" : "R5";
              chkEq(rq, "write cmd", (nTx == 0) ? 0 : txCmd[0],
                    (st == 0) ? 2 : (st == 1) ? 3 : 0);
              chkEq(rq, "write tx count", nTx, (st <= 1) ? 1 : 0);
            end
            2: begin
              snoop(1, a, 0, 0);
              rq = (st == 3) ? "R7" : "R9";
              ns = (st == 0) ? 0 : 1;
              chkEq(rq, "snoop read shared", snSh, (st != 0) ? 1 : 0);
              chkEq(rq, "snoop read flush", snFl, (st == 3) ? 1 : 0);
              if (st == 3) chkEq(rq, "flush data", snDt, int'(w));
            end
            default: begin
              snoop((ev == 3) ? 2 : 3, a, 0, 0);
              rq = "R8"; ns = 0;
              chkEq(rq, "snoop inval shared", snSh, 0);
              chkEq(rq, "snoop inval flush", snFl, (st == 3 && ev == 3) ? 1 : 0);
              if (st == 3) chkEq(rq, "flush data", snDt, int'(w));
            end
          endcase
          if (pr == 0) begin
            cpuOp(1, a, 8'hEE, 0, 8'h00, 0);
            chkEq(rq, "state probe by write", (nTx == 0) ? 0 : txCmd[0],
                  (ns == 0) ? 2 : (ns == 1) ? 3 : 0);
          end else begin
            snoop(1, a, 0, 0);
            chkEq(rq, "state probe by snoop", snSh * 2 + snFl,
                  (ns == 0) ? 0 : (ns == 3) ? 3 : 2);
          end
        end
      end
    end

    // R11: dirty eviction writes back first, clean eviction is silent
    cpuOp(1, {3'd1, 3'd3}, 8'h55, 0, 8'h00, 0);
    cpuOp(0, {3'd2, 3'd3}, 8'h00, 0, 8'h66, 0);
    chkEq("R11", "conflict tx count", nTx, 2);
    chkEq("R11", "first cmd write-back", txCmd[0], 4);
    chkEq("R11", "write-back addr", txAddr[0], int'({3'd1, 3'd3}));
    chkEq("R11", "write-back data", txData[0], 8'h55);
    chkEq("R11", "second cmd read", txCmd[1], 1);
    chkEq("R11", "miss addr", txAddr[1], int'({3'd2, 3'd3}));
    chkEq("R11", "fill data", gotData, 8'h66);
    snoop(1, {3'd1, 3'd3}, 0, 0);
    chkEq("R11", "old line gone", snSh, 0);
    cpuOp(0, {3'd3, 3'd3}, 8'h00, 0, 8'h77, 0);
    chkEq("R11", "clean eviction tx count", nTx, 1);
    chkEq("R11", "clean eviction cmd", txCmd[0], 1);

    // R12: stall until grant, no early state change
    fork
      cpuOp(0, {3'd6, 3'd1}, 8'h00, 0, 8'h5A, 4);
      begin
        snoop(1, {3'd6, 3'd1}, 0, 2);
        chkEq("R12", "state unchanged before grant", snSh, 0);
      end
    join
    chkEq("R12", "stalled tx count", nTx, 1);
    chkEq("R12", "stalled read data", gotData, 8'h5A);

    // R6: upgrade converts after racing invalidation
    snoop(1, {3'd6, 3'd1}, 0, 0);
    chkEq("R9", "exclusive line answers shared", snSh, 1);
    fork
      cpuOp(1, {3'd6, 3'd1}, 8'h99, 0, 8'h00, 3);
      begin
        snoop(2, {3'd6, 3'd1}, 0, 1);
        chkEq("R8", "shared line invalidated without flush", snFl, 0);
      end
    join
    chkEq("R6", "command after invalidation", txCmd[0], 2);

    // R13: snoop wins against an exclusive write hit
    cpuOp(0, {3'd7, 3'd2}, 8'h00, 0, 8'h31, 0);
    fork
      cpuOp(1, {3'd7, 3'd2}, 8'h42, 0, 8'h00, 0);
      snoop(1, {3'd7, 3'd2}, 0, 0);
    join
    chkEq("R13", "snoop saw clean copy", snSh * 2 + snFl, 2);
    chkEq("R13", "write issues upgrade", (nTx == 0) ? 0 : txCmd[0], 3);
    cpuOp(0, {3'd7, 3'd2}, 8'h00, 0, 8'h00, 0);
    chkEq("R13", "written word kept", gotData, 8'h42);

    // R10: clean supply only under the selector
    cpuOp(0, {3'd4, 3'd6}, 8'h00, 0, 8'h2C, 0);
    snoop(1, {3'd4, 3'd6}, 1, 0);
    chkEq("R10", "exclusive supply flush", snFl, 1);
    chkEq("R10", "exclusive supply data", snDt, 8'h2C);
    snoop(1, {3'd4, 3'd6}, 0, 0);
    chkEq("R10", "no supply without selector", snFl, 0);
    snoop(1, {3'd4, 3'd6}, 1, 0);
    chkEq("R10", "shared supply flush", snFl, 1);
    snoop(1, {3'd2, 3'd6}, 1, 0);
    chkEq("R10", "no supply for absent line", snFl, 0);

    summary();
  end

endmodule